// File: doc/BRIEF.md
# Page Frame Allocation Map

This block keeps the system-wide record of which physical page frames are in use. The physical memory is split into fixed-size frames (16 MB of 4 KB frames by default, giving 4096 frames with a 12-bit frame number). One status bit per frame records whether the frame is allocated or free. The lowest frames, by default the first 1 MB (frames 000H to 0FFH), hold the resident operating system. They are marked allocated from reset and can never be handed out, so allocation begins at physical address 100000H.

A requester presents a process size in bytes. The block divides the size by the page size and rounds up to get a frame count, so a 3A00H-byte process needs four frames. If fewer frames are free than that count, the block rejects the request and changes nothing. Otherwise it scans upward through the map and hands out free frame numbers, lowest first, on a valid/ready stream that can feed a page-map-table writer. The frames need not be contiguous. When a process ends or is swapped out, a separate release port returns its frames one at a time. A running free-frame count is kept on every grant and release.

The controller has three states. `ST_IDLE` accepts a request. From there it either stays in `ST_IDLE` (on a reject or a zero-byte request) or moves to `ST_SCAN` (the request is accepted). `ST_SCAN` steps the frame pointer past allocated frames and moves to `ST_OFFER` on the first free frame. `ST_OFFER` holds a frame on the stream until it is accepted. After an accepted frame there are three transitions: back to `ST_IDLE` when it was the last frame, staying in `ST_OFFER` when the next frame is free, and back to `ST_SCAN` otherwise.

Top module: `pfa_frame_map`

## Requirements
- R1: After reset, every frame below RSVD_FRAMES is allocated and every other frame is free. `free_count` equals the total frame count minus RSVD_FRAMES, `req_ready` is 1, and `grant_valid`, `req_reject` and `rel_bad` are 0.
- R2: The frame count of a request is `req_bytes` divided by 2^PAGE_BITS, rounded up. An accepted request delivers exactly that many frames.
- R3: A request accepted while `req_ready` is 1 and needing more frames than `free_count` raises `req_reject` for one cycle, starting on the clock edge after acceptance. It grants no frame, and `free_count` and the map stay unchanged.
- R4: Each request begins its scan at frame RSVD_FRAMES. Every granted frame is the lowest free frame above the previous grant of the same request, so grants within a request ascend and may skip allocated frames.
- R5: `grant_frame` is valid while `grant_valid` is 1. It is held stable until `grant_ready` is 1. `grant_last` is 1 only with the final frame of a request.
- R6: No frame number below RSVD_FRAMES is ever granted.
- R7: Releasing an allocated frame at or above RSVD_FRAMES marks it free. After the next edge, `free_count` is one higher than it would otherwise be, and the frame can be granted again.
- R8: Releasing a frame that is already free, or a reserved frame, leaves the map and `free_count` unchanged. It raises `rel_bad` for one cycle after the edge.
- R9: When a grant handshake and a valid release fall on the same edge, `free_count` changes by the sum of both effects.
- R10: A zero-byte request grants nothing and is not rejected. `req_ready` stays 1.
- R11: While `grant_ready` stays 1 and the next frame above a granted one is free, that next frame is offered in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Allocation request present |
| req_bytes | input | SIZE_BITS | Process size in bytes |
| req_ready | output | 1 | Controller idle, request taken this cycle |
| req_reject | output | 1 | One-cycle pulse: request refused for lack of frames |
| grant_valid | output | 1 | A granted frame number is offered |
| grant_ready | input | 1 | Consumer takes the offered frame |
| grant_frame | output | FRAME_BITS | Offered frame number |
| grant_last | output | 1 | Offered frame is the final one of the request |
| rel_valid | input | 1 | Frame release present |
| rel_frame | input | FRAME_BITS | Frame number being released |
| rel_bad | output | 1 | One-cycle pulse: last release was ignored |
| free_count | output | FRAME_BITS+1 | Number of free allocatable frames |

## Verification
A grant handshake and a release can fall on the same clock edge, and both move the free-frame counter and the map. The bench makes this happen by driving a release of an already allocated frame in the same cycle as it accepts an offered frame. In that run the first offer is also stalled for a few cycles. The outcome is judged after the edge: `free_count` must equal the model count with both changes applied, and the next offers must still be the lowest free frames above the last grant. The bench also drives releases of free and reserved frames next to live traffic and checks that they only raise `rel_bad`.

// File: rtl/pfa_pkg.sv
package pfa_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SCAN  = 2'd1,
        ST_OFFER = 2'd2
    } pfa_state_e;
endpackage

// File: rtl/pfa_sizer.sv
// Converts a byte size to a frame count with round-up.
module pfa_sizer #(
    parameter int SIZE_BITS = 24,
    parameter int PAGE_BITS = 12,
    localparam int NEED_W   = SIZE_BITS - PAGE_BITS + 1
) (
    input  logic [SIZE_BITS-1:0] bytes_in,
    output logic [NEED_W-1:0]    need
);
    logic [NEED_W-1:0] whole;
    logic              partial;

    always_comb begin
        whole   = {1'b0, bytes_in[SIZE_BITS-1:PAGE_BITS]};
        partial = |bytes_in[PAGE_BITS-1:0];
        need    = whole + NEED_W'(partial);
    end
endmodule

// File: rtl/pfa_bitmap.sv
// Frame status bitmap (1 = allocated) with free counter and release checking.
module pfa_bitmap #(
    parameter int FRAME_BITS  = 12,
    parameter int RSVD_FRAMES = 256,
    localparam int FRAMES     = 1 << FRAME_BITS,
    localparam int CNT_W      = FRAME_BITS + 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  take_en,
    input  logic [FRAME_BITS-1:0] take_idx,
    input  logic                  rel_en,
    input  logic [FRAME_BITS-1:0] rel_idx,
    output logic [FRAMES-1:0]     busy_map,
    output logic [CNT_W-1:0]      free_cnt,
    output logic                  rel_bad
);
    localparam logic [FRAMES-1:0] RST_MAP   = {FRAMES{1'b1}} >> (FRAMES - RSVD_FRAMES);
    localparam logic [CNT_W-1:0]  RST_FREE  = CNT_W'(FRAMES - RSVD_FRAMES);
    localparam logic [FRAME_BITS-1:0] FIRST = FRAME_BITS'(RSVD_FRAMES);

    logic rel_ok;

    always_comb begin
        rel_ok = rel_en && (rel_idx >= FIRST) && busy_map[rel_idx];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_map <= RST_MAP;
            free_cnt <= RST_FREE;
            rel_bad  <= 1'b0;
        end else begin
            rel_bad <= rel_en && !rel_ok;
            if (rel_ok)  busy_map[rel_idx]  <= 1'b0;
            if (take_en) busy_map[take_idx] <= 1'b1;
            unique case ({rel_ok, take_en})
                2'b10:   free_cnt <= free_cnt + 1'b1;
                2'b01:   free_cnt <= free_cnt - 1'b1;
                default: free_cnt <= free_cnt;
            endcase
        end
    end
endmodule

// File: rtl/pfa_ctrl.sv
// Request/scan/offer state machine.
module pfa_ctrl
    import pfa_pkg::*;
#(
    parameter int FRAME_BITS  = 12,
    parameter int RSVD_FRAMES = 256,
    parameter int NEED_W      = 13,
    localparam int FRAMES     = 1 << FRAME_BITS,
    localparam int CNT_W      = FRAME_BITS + 1,
    localparam int CMP_W      = (NEED_W > CNT_W) ? NEED_W : CNT_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic [NEED_W-1:0]     need,
    input  logic [CNT_W-1:0]      free_cnt,
    input  logic [FRAMES-1:0]     busy_map,
    input  logic                  grant_ready,
    output logic                  req_ready,
    output logic                  req_reject,
    output logic                  grant_valid,
    output logic [FRAME_BITS-1:0] grant_frame,
    output logic                  grant_last,
    output logic                  take_en,
    output logic [FRAME_BITS-1:0] take_idx
);
    localparam logic [FRAME_BITS-1:0] FIRST = FRAME_BITS'(RSVD_FRAMES);

    pfa_state_e              state_q, state_d;
    logic [FRAME_BITS-1:0]   ptr_q, ptr_d, ptr_nx;
    logic [NEED_W-1:0]       left_q, left_d;
    logic                    rej_q, rej_d;
    logic                    short_fall;

    always_comb begin
        ptr_nx     = ptr_q + FRAME_BITS'(1);
        short_fall = CMP_W'(need) > CMP_W'(free_cnt);
    end

    // next state
    always_comb begin
        state_d = state_q;
        ptr_d   = ptr_q;
        left_d  = left_q;
        rej_d   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    if (short_fall) begin
                        rej_d = 1'b1;
                    end else if (need != '0) begin
                        state_d = ST_SCAN;
                        ptr_d   = FIRST;
                        left_d  = need;
                    end
                end
            end
            ST_SCAN: begin
                if (!busy_map[ptr_q]) state_d = ST_OFFER;
                else                  ptr_d   = ptr_nx;
            end
            ST_OFFER: begin
                if (grant_ready) begin
                    ptr_d  = ptr_nx;
                    left_d = left_q - 1'b1;
                    if (left_q == NEED_W'(1))  state_d = ST_IDLE;
                    else if (!busy_map[ptr_nx]) state_d = ST_OFFER;
                    else                        state_d = ST_SCAN;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ptr_q   <= FIRST;
            left_q  <= '0;
            rej_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            ptr_q   <= ptr_d;
            left_q  <= left_d;
            rej_q   <= rej_d;
        end
    end

    // outputs
    always_comb begin
        req_ready   = (state_q == ST_IDLE);
        req_reject  = rej_q;
        grant_valid = (state_q == ST_OFFER);
        grant_frame = ptr_q;
        grant_last  = (state_q == ST_OFFER) && (left_q == NEED_W'(1));
        take_en     = (state_q == ST_OFFER) && grant_ready;
        take_idx    = ptr_q;
    end
endmodule

// File: rtl/pfa_frame_map.sv
module pfa_frame_map #(
    parameter int FRAME_BITS  = 12,
    parameter int PAGE_BITS   = 12,
    parameter int SIZE_BITS   = 24,
    parameter int RSVD_FRAMES = 256,
    localparam int FRAMES     = 1 << FRAME_BITS,
    localparam int NEED_W     = SIZE_BITS - PAGE_BITS + 1,
    localparam int CNT_W      = FRAME_BITS + 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic [SIZE_BITS-1:0]  req_bytes,
    output logic                  req_ready,
    output logic                  req_reject,
    output logic                  grant_valid,
    input  logic                  grant_ready,
    output logic [FRAME_BITS-1:0] grant_frame,
    output logic                  grant_last,
    input  logic                  rel_valid,
    input  logic [FRAME_BITS-1:0] rel_frame,
    output logic                  rel_bad,
    output logic [CNT_W-1:0]      free_count
);
    logic [NEED_W-1:0]     need;
    logic [FRAMES-1:0]     busy_map;
    logic                  take_en;
    logic [FRAME_BITS-1:0] take_idx;

    pfa_sizer #(
        .SIZE_BITS (SIZE_BITS),
        .PAGE_BITS (PAGE_BITS)
    ) u_sizer (
        .bytes_in (req_bytes),
        .need     (need)
    );

    pfa_bitmap #(
        .FRAME_BITS  (FRAME_BITS),
        .RSVD_FRAMES (RSVD_FRAMES)
    ) u_map (
        .clk      (clk),
        .rst_n    (rst_n),
        .take_en  (take_en),
        .take_idx (take_idx),
        .rel_en   (rel_valid),
        .rel_idx  (rel_frame),
        .busy_map (busy_map),
        .free_cnt (free_count),
        .rel_bad  (rel_bad)
    );

    pfa_ctrl #(
        .FRAME_BITS  (FRAME_BITS),
        .RSVD_FRAMES (RSVD_FRAMES),
        .NEED_W      (NEED_W)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .need        (need),
        .free_cnt    (free_count),
        .busy_map    (busy_map),
        .grant_ready (grant_ready),
        .req_ready   (req_ready),
        .req_reject  (req_reject),
        .grant_valid (grant_valid),
        .grant_frame (grant_frame),
        .grant_last  (grant_last),
        .take_en     (take_en),
        .take_idx    (take_idx)
    );
endmodule

// File: rtl/pfa_frame_map_chk.sv
module pfa_frame_map_chk #(
    parameter int FRAME_BITS  = 12,
    parameter int RSVD_FRAMES = 256,
    localparam int FRAMES     = 1 << FRAME_BITS,
    localparam int CNT_W      = FRAME_BITS + 1
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  req_ready,
    input logic                  req_reject,
    input logic                  grant_valid,
    input logic                  grant_ready,
    input logic [FRAME_BITS-1:0] grant_frame,
    input logic                  rel_valid,
    input logic                  rel_bad,
    input logic [CNT_W-1:0]      free_count
);
    AST_FREE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        free_count <= CNT_W'(FRAMES - RSVD_FRAMES)); // R1
    AST_REJECT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_reject |-> !grant_valid); // R3
    AST_GRANT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && !grant_ready) |=> (grant_valid && $stable(grant_frame))); // R5
    AST_NO_RSVD_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> (grant_frame >= FRAME_BITS'(RSVD_FRAMES))); // R6
    AST_GRANT_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && grant_ready && !rel_valid) |=> (free_count == $past(free_count) - 1'b1)); // R9
    AST_RELEASE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_valid && !(grant_valid && grant_ready)) |=>
        (rel_bad ? (free_count == $past(free_count)) : (free_count == $past(free_count) + 1'b1))); // R8
    AST_ONE_SIDE: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_ready && grant_valid)); // R5
endmodule

bind pfa_frame_map pfa_frame_map_chk #(
    .FRAME_BITS  (FRAME_BITS),
    .RSVD_FRAMES (RSVD_FRAMES)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_ready   (req_ready),
    .req_reject  (req_reject),
    .grant_valid (grant_valid),
    .grant_ready (grant_ready),
    .grant_frame (grant_frame),
    .rel_valid   (rel_valid),
    .rel_bad     (rel_bad),
    .free_count  (free_count)
);

// File: tb/pfa_frame_map_tb.sv
`timescale 1ns/1ps
module pfa_frame_map_tb;
    localparam int FB = 5;
    localparam int PB = 4;
    localparam int SB = 10;
    localparam int RS = 4;
    localparam int NF = 1 << FB;
    localparam int PG = 1 << PB;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [SB-1:0] req_bytes = '0;
    logic          req_ready, req_reject, grant_valid, grant_last, rel_bad;
    logic          grant_ready = 1'b0;
    logic [FB-1:0] grant_frame;
    logic          rel_valid = 1'b0;
    logic [FB-1:0] rel_frame = '0;
    logic [FB:0]   free_count;

    int checks = 0;
    int errs   = 0;
    int cycles = 0;
    bit mdl_busy [NF];
    int mdl_free;

    always #4 clk = ~clk;

    pfa_frame_map #(
        .FRAME_BITS (FB), .PAGE_BITS (PB), .SIZE_BITS (SB), .RSVD_FRAMES (RS)
    ) u_dut (
        .clk (clk), .rst_n (rst_n),
        .req_valid (req_valid), .req_bytes (req_bytes),
        .req_ready (req_ready), .req_reject (req_reject),
        .grant_valid (grant_valid), .grant_ready (grant_ready),
        .grant_frame (grant_frame), .grant_last (grant_last),
        .rel_valid (rel_valid), .rel_frame (rel_frame),
        .rel_bad (rel_bad), .free_count (free_count)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int next_free(input int from);
        for (int i = from; i < NF; i++) if (!mdl_busy[i]) return i;
        return -1;
    endfunction

    task automatic do_req(input int nbytes, input int conc_rel, input bit stall);
        int  need, got, prev_f, prev_c, cyc, f, exp_f;
        bit  exp_rej, pend, stalled;
        need    = (nbytes + PG - 1) / PG;
        exp_rej = need > mdl_free;
        @(negedge clk);
        chk(req_ready == 1'b1, "R3 ready", int'(req_ready), 1);
        req_valid = 1'b1;
        req_bytes = SB'(nbytes);
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_reject == exp_rej, "R3 reject", int'(req_reject), int'(exp_rej));
        if (exp_rej) begin
            chk(free_count == mdl_free, "R3 count kept", int'(free_count), mdl_free);
            chk(grant_valid == 1'b0, "R3 no grant", int'(grant_valid), 0);
            return;
        end
        if (need == 0) begin
            chk(!grant_valid && req_ready, "R10 zero size", int'(grant_valid), 0);
            return;
        end
        got = 0; prev_f = -1; prev_c = 0; cyc = 0; pend = 1'b0; stalled = 1'b0;
        grant_ready = 1'b1;
        while (got < need && cyc < 2000) begin
            if (grant_valid) begin
                f = int'(grant_frame);
                if (stall && !stalled) begin
                    grant_ready = 1'b0;
                    for (int k = 0; k < 3; k++) begin
                        @(negedge clk); cyc++;
                        chk(grant_valid && int'(grant_frame) == f, "R5 hold", int'(grant_frame), f);
                    end
                    grant_ready = 1'b1;
                    stalled = 1'b1;
                    prev_c = cyc - 1;
                end
                exp_f = next_free(got == 0 ? RS : prev_f + 1);
                chk(f == exp_f, "R4 frame order", f, exp_f);
                chk(f >= RS, "R6 reserved", f, RS);
                chk(grant_last == (got == need - 1), "R5 last", int'(grant_last), int'(got == need - 1));
                if (prev_f >= 0 && f == prev_f + 1)
                    chk(cyc - prev_c == 1, "R11 back to back", cyc - prev_c, 1);
                if (conc_rel >= 0 && got == 0) begin
                    rel_valid = 1'b1;
                    rel_frame = FB'(conc_rel);
                    pend = 1'b1;
                end
                if (f >= 0 && f < NF) mdl_busy[f] = 1'b1;
                mdl_free--;
                got++;
                prev_f = f;
                prev_c = cyc;
            end
            @(negedge clk);
            cyc++;
            if (pend) begin
                rel_valid = 1'b0;
                mdl_busy[conc_rel] = 1'b0;
                mdl_free++;
                chk(free_count == mdl_free, "R9 same edge", int'(free_count), mdl_free);
                chk(rel_bad == 1'b0, "R9 release ok", int'(rel_bad), 0);
                pend = 1'b0;
            end
        end
        grant_ready = 1'b0;
        chk(got == need, "R2 frame count", got, need);
        chk(!grant_valid && req_ready, "R2 back idle", int'(grant_valid), 0);
        chk(free_count == mdl_free, "R7 count", int'(free_count), mdl_free);
    endtask

    task automatic do_rel(input int f);
        bit exp_bad;
        exp_bad = (f < RS) || !mdl_busy[f];
        @(negedge clk);
        rel_valid = 1'b1;
        rel_frame = FB'(f);
        @(negedge clk);
        rel_valid = 1'b0;
        if (exp_bad) chk(rel_bad == 1'b1, "R8 flag", int'(rel_bad), 1);
        else begin
            chk(rel_bad == 1'b0, "R7 flag", int'(rel_bad), 0);
            mdl_busy[f] = 1'b0;
            mdl_free++;
        end
        chk(free_count == mdl_free, exp_bad ? "R8 count" : "R7 count", int'(free_count), mdl_free);
    endtask

    task automatic release_all();
        for (int i = RS; i < NF; i++) if (mdl_busy[i]) do_rel(i);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errs);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            checks++;
            errs++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
            finish_run();
        end
    end

    initial begin
        for (int i = 0; i < NF; i++) mdl_busy[i] = (i < RS);
        mdl_free = NF - RS;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(free_count == NF - RS, "R1 free count", int'(free_count), NF - RS);
        chk(req_ready && !grant_valid && !req_reject && !rel_bad, "R1 idle", int'(req_ready), 1);
        for (int i = 0; i < RS; i++) do_rel(i);   // R8 reserved release
        do_rel(RS);                               // R8 free-frame release
        // R2 sweep of sizes, including exact fit and one frame too many
        for (int s = 0; s <= (NF - RS + 1) * PG; s++) begin
            do_req(s, -1, 1'b0);
            release_all();
        end
        // R4 fragmented map
        do_req((NF - RS) * PG, -1, 1'b0);
        for (int i = RS + 1; i < NF; i += 2) do_rel(i);
        do_req(5 * PG, -1, 1'b0);
        do_req(10 * PG, -1, 1'b0);                // R3 too few
        do_req(9 * PG, -1, 1'b0);
        do_req(1, -1, 1'b0);                      // R3 map full
        do_req(0, -1, 1'b0);                      // R10
        do_rel(RS + 1);
        do_rel(RS + 1);                           // R8 double release
        // R9 concurrent release during a stalled grant
        for (int i = 20; i < 28; i++) do_rel(i);
        do_req(4 * PG, 30, 1'b1);
        release_all();
        do_req(3 * PG - 5, -1, 1'b0);             // R7 frames reusable
        release_all();
        chk(free_count == NF - RS, "R7 all free", int'(free_count), NF - RS);
        finish_run();
    end
endmodule